// File: doc/BRIEF.md
# Floating-Point Four-Lane Min/Max Reduction

This block takes one 128-bit vector of four single-precision lanes and reduces it to one value. The reduction uses one of four operations: maximum, minimum, number-preferring maximum or number-preferring minimum. The operation comes from an instruction word, and the block also decides whether that word is a legal encoding. An illegal word raises an undefined flag and gives a zero result. A legal word gives the reduced value in the low 32 bits of a 64-bit result, with the upper half cleared.

The reduction always runs as a fixed pairwise tree, so NaN propagation does not depend on the implementation. One comparator reduces lanes 0 and 1, another reduces lanes 2 and 3, and a third combines those two results with the lane 0/1 result as its first operand. The comparator handles signed zeros, infinities, subnormals and the quiet and signalling NaN rules. The whole tree is combinational and sits in front of a single output register.

Both ends use a valid/ready handshake. An input is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. A result that is held with `out_valid` high and `out_ready` low stays unchanged until it is taken. Control pins are plain.

Top module: `fp_lane_minmax_reduce`

## Requirements
- R1: A word is legal only when bit 29 = 1, bit 30 = 1, bit 22 = 0 and bits 16:12 equal 0x0C or 0x0F. Any other word gives `out_undef` = 1 and `out_result` = 0. Bits not named here are not examined.
- R2: Bit 23 of the word selects minimum when it is 1 and maximum when it is 0. Opcode 0x0F selects the plain variants and opcode 0x0C selects the number-preferring variants.
- R3: The reduction is op(op(lane0, lane1), op(lane2, lane3)). Lane k occupies vector bits 32k+31:32k, and the left argument is the first operand.
- R4: `out_result[31:0]` holds the reduced value and `out_result[63:32]` is zero.
- R5: In the plain variants, a NaN operand produces that NaN in quiet form, meaning mantissa bit 22 is set. When both operands are NaN, the first operand wins.
- R6: In the number variants, a quiet NaN paired with a non-NaN yields the non-NaN. Two quiet NaNs yield the first operand.
- R7: In the number variants, a signalling NaN operand (exponent all ones, bit 22 = 0, mantissa nonzero) produces that NaN in quiet form. The first operand's signalling NaN wins.
- R8: For zeros of opposite sign, maximum returns +0 (0x00000000) and minimum returns -0 (0x80000000).
- R9: Non-NaN values are ordered numerically, including infinities, negative values and subnormals.
- R10: A word accepted at a clock edge appears on the outputs with `out_valid` high right after that edge. No result appears without an accepted input.
- R11: While `out_valid` = 1 and `out_ready` = 0, `in_ready` is 0 and the outputs hold steady. Otherwise `in_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word and vector are valid |
| in_ready | output | 1 | Block can accept an input this cycle |
| in_insn | input | 32 | Instruction word |
| in_vec | input | 128 | Source vector, four 32-bit lanes |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 64 | Zero-extended reduced value |
| out_undef | output | 1 | Instruction word was not a legal encoding |

## Verification
The hardest case to reach is one where the fixed tree order changes the answer. In the number variants, put a signalling NaN in lane 2 and a quiet NaN in lane 1. The second-level comparator then sees an already quieted NaN, so the number from lane 0 wins. A reduction that scanned every lane for signalling NaNs would return the NaN instead. The stimulus builds such vectors on purpose, and also puts NaNs with different payloads in lanes 0 and 2 to show which operand has priority. A pseudo-random phase then draws lanes from a pool of special values while `out_ready` is toggled, so held results and stalled inputs are exercised together.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;
  localparam int ELEM_W  = 32;
  localparam int EXP_W   = 8;
  localparam int MAN_W   = ELEM_W - EXP_W - 1;
  localparam int QBIT    = MAN_W - 1;

  typedef enum logic {PREF_PLAIN = 1'b0, PREF_NUMBER = 1'b1} pref_e;

  typedef struct packed {
    logic  is_min;
    pref_e pref;
  } op_cfg_t;

  typedef struct packed {
    logic nan;
    logic snan;
    logic qnan;
  } cls_t;

  function automatic cls_t classify(input logic [ELEM_W-1:0] v);
    cls_t c;
    logic exp_ones;
    logic man_nz;
    exp_ones = &v[ELEM_W-2:MAN_W];
    man_nz   = |v[MAN_W-1:0];
    c.nan  = exp_ones && man_nz;
    c.qnan = c.nan && v[QBIT];
    c.snan = c.nan && !v[QBIT];
    return c;
  endfunction

  function automatic logic [ELEM_W-1:0] make_quiet(input logic [ELEM_W-1:0] v);
    logic [ELEM_W-1:0] q;
    q = v;
    q[QBIT] = 1'b1;
    return q;
  endfunction

  // Monotonic unsigned key: larger key means larger numeric value, -0 < +0.
  function automatic logic [ELEM_W-1:0] order_key(input logic [ELEM_W-1:0] v);
    return v[ELEM_W-1] ? ~v : (v | {1'b1, {(ELEM_W-1){1'b0}}});
  endfunction
endpackage

// File: rtl/fpmm_decode.sv
module fpmm_decode
  import fpmm_pkg::*;
#(
  parameter int INSN_W = 32
) (
  input  logic [INSN_W-1:0] insn,
  output op_cfg_t           cfg,
  output logic              undef
);
  localparam int Q_POS    = 30;
  localparam int U_POS    = 29;
  localparam int SZ_LO    = 22;
  localparam int SZ_HI    = 23;
  localparam int OPC_LO   = 12;
  localparam int OPC_W    = 5;
  localparam logic [OPC_W-1:0] OPC_NUM   = 5'h0C;
  localparam logic [OPC_W-1:0] OPC_PLAIN = 5'h0F;

  logic [OPC_W-1:0] opc;
  logic             opc_known;
  logic             fields_ok;

  always_comb begin
    opc        = insn[OPC_LO +: OPC_W];
    opc_known  = (opc == OPC_NUM) || (opc == OPC_PLAIN);
    fields_ok  = insn[U_POS] && insn[Q_POS] && !insn[SZ_LO];
    undef      = !(opc_known && fields_ok);
    cfg.is_min = insn[SZ_HI];
    cfg.pref   = (opc == OPC_NUM) ? PREF_NUMBER : PREF_PLAIN;
  end
endmodule

// File: rtl/fpmm_pair.sv
module fpmm_pair
  import fpmm_pkg::*;
(
  input  logic [ELEM_W-1:0] op_a,
  input  logic [ELEM_W-1:0] op_b,
  input  op_cfg_t           cfg,
  output logic [ELEM_W-1:0] y
);
  cls_t              ca;
  cls_t              cb;
  logic              a_ge;
  logic [ELEM_W-1:0] ordered;
  logic              num_mode;

  always_comb begin
    ca       = classify(op_a);
    cb       = classify(op_b);
    a_ge     = order_key(op_a) >= order_key(op_b);
    ordered  = (cfg.is_min ^ a_ge) ? op_a : op_b;
    num_mode = (cfg.pref == PREF_NUMBER);
    if (num_mode && (ca.snan || cb.snan))
      y = ca.snan ? make_quiet(op_a) : make_quiet(op_b);
    else if (num_mode && ca.qnan && !cb.nan)
      y = op_b;
    else if (num_mode && cb.qnan && !ca.nan)
      y = op_a;
    else if (ca.nan)
      y = make_quiet(op_a);
    else if (cb.nan)
      y = make_quiet(op_b);
    else
      y = ordered;
  end
endmodule

// File: rtl/fpmm_tree.sv
module fpmm_tree
  import fpmm_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [LANES*ELEM_W-1:0] vec,
  input  op_cfg_t                 cfg,
  output logic [ELEM_W-1:0]       y
);
  localparam int PAIRS = LANES / 2;

  logic [ELEM_W-1:0] level1 [PAIRS];

  for (genvar g = 0; g < PAIRS; g++) begin : g_lvl1
    fpmm_pair u_pair (
      .op_a (vec[(2*g)*ELEM_W   +: ELEM_W]),
      .op_b (vec[(2*g+1)*ELEM_W +: ELEM_W]),
      .cfg  (cfg),
      .y    (level1[g])
    );
  end

  fpmm_pair u_root (
    .op_a (level1[0]),
    .op_b (level1[1]),
    .cfg  (cfg),
    .y    (y)
  );
endmodule

// File: rtl/fp_lane_minmax_reduce.sv
module fp_lane_minmax_reduce
  import fpmm_pkg::*;
#(
  parameter int INSN_W = 32,
  parameter int LANES  = 4,
  parameter int RES_W  = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [INSN_W-1:0]       in_insn,
  input  logic [LANES*ELEM_W-1:0] in_vec,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [RES_W-1:0]        out_result,
  output logic                    out_undef
);
  localparam int PAD_W = RES_W - ELEM_W;

  op_cfg_t           cfg;
  logic              undef_c;
  logic [ELEM_W-1:0] tree_y;
  logic              take;

  fpmm_decode #(.INSN_W(INSN_W)) u_dec (
    .insn  (in_insn),
    .cfg   (cfg),
    .undef (undef_c)
  );

  fpmm_tree #(.LANES(LANES)) u_tree (
    .vec (in_vec),
    .cfg (cfg),
    .y   (tree_y)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_undef  <= 1'b0;
    end else if (take) begin
      out_valid  <= 1'b1;
      out_undef  <= undef_c;
      out_result <= undef_c ? '0 : {{PAD_W{1'b0}}, tree_y};
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/fpmm_checker.sv
module fpmm_checker (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [63:0]  out_result,
  input logic         out_undef
);
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_undef));

  a_r11_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) && !(out_valid && !out_ready) |=> !out_valid);

  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_result[63:32] == 32'h0);

  a_r1_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_undef |-> out_result == 64'h0);

  a_r5_nan_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (&out_result[30:23]) && (|out_result[22:0]) |-> out_result[22]);
endmodule

bind fp_lane_minmax_reduce fpmm_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result),
  .out_undef  (out_undef)
);

// File: tb/fp_lane_minmax_reduce_test.sv
module fp_lane_minmax_reduce_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [31:0]  in_insn = '0;
  logic [127:0] in_vec = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [63:0]  out_result;
  logic         out_undef;

  int  n_checks = 0;
  int  n_fail = 0;
  bit  bp_en = 1'b0;
  int  cyc = 0;
  bit  done = 1'b0;

  logic [64:0] q_exp[$];
  string       q_tag[$];

  always #4 clk = ~clk;

  fp_lane_minmax_reduce uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_insn(in_insn), .in_vec(in_vec), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_undef(out_undef)
  );

  localparam logic [31:0] P1 = 32'h3F800000, N1 = 32'hBF800000;
  localparam logic [31:0] PINF = 32'h7F800000, NINF = 32'hFF800000;
  localparam logic [31:0] PZ = 32'h00000000, NZ = 32'h80000000;
  localparam logic [31:0] QN1 = 32'h7FC00001, QN2 = 32'hFFC00077;
  localparam logic [31:0] SN1 = 32'h7F800005, SN2 = 32'hFF812345;
  localparam logic [31:0] DEN = 32'h00000001, PI = 32'h40490FDB, N2 = 32'hC0000000;

  function automatic logic [31:0] mk_insn(bit q, bit u, logic [1:0] sz, logic [4:0] opc);
    return {1'b0, q, u, 5'b01110, sz, 5'b11000, opc, 2'b10, 5'd3, 5'd7};
  endfunction

  function automatic bit is_nan(logic [31:0] v);
    return v[30:23] == 8'hFF && v[22:0] != 0;
  endfunction

  function automatic bit greater(logic [31:0] a, logic [31:0] b);
    if (a == b) return 1'b0;
    if (a[31] != b[31]) return !a[31];
    if (!a[31]) return a[30:0] > b[30:0];
    return a[30:0] < b[30:0];
  endfunction

  function automatic logic [31:0] ref_op(logic [31:0] a, logic [31:0] b, bit mn, bit num);
    bit an = is_nan(a), bn = is_nan(b);
    bit as_ = an && !a[22], bs = bn && !b[22];
    if (num) begin
      if (as_) return a | 32'h00400000;
      if (bs) return b | 32'h00400000;
      if (an && !bn) return b;
      if (bn && !an) return a;
    end
    if (an) return a | 32'h00400000;
    if (bn) return b | 32'h00400000;
    if (mn) return greater(a, b) ? b : a;
    return greater(a, b) ? a : b;
  endfunction

  function automatic logic [64:0] ref_model(logic [31:0] w, logic [127:0] v);
    bit legal = w[29] && w[30] && !w[22] && (w[16:12] == 5'h0C || w[16:12] == 5'h0F);
    bit mn = w[23], num = (w[16:12] == 5'h0C);
    logic [31:0] r01, r23;
    if (!legal) return {1'b1, 64'h0};
    r01 = ref_op(v[31:0], v[63:32], mn, num);
    r23 = ref_op(v[95:64], v[127:96], mn, num);
    return {1'b0, 32'h0, ref_op(r01, r23, mn, num)};
  endfunction

  task automatic send(logic [31:0] w, logic [31:0] l0, logic [31:0] l1,
                      logic [31:0] l2, logic [31:0] l3, string tag);
    @(negedge clk);
    in_valid = 1'b1;
    in_insn  = w;
    in_vec   = {l3, l2, l1, l0};
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    q_exp.push_back(ref_model(w, {l3, l2, l1, l0}));
    q_tag.push_back(tag);
    #1;
    in_valid = 1'b0;
  endtask

  // Back-pressure driver: changes away from both sampling points.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #2;
    out_ready <= !bp_en || (cyc % 3 != 0);
  end

  // Scoreboard monitor.
  logic        prev_stall = 1'b0;
  logic [64:0] prev_out = '0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (prev_stall) begin
        n_checks++;
        if (!out_valid || {out_undef, out_result} != prev_out) begin
          n_fail++;
          $display("FAIL R11 held output changed: got v=%0b %h exp %h", out_valid,
                   {out_undef, out_result}, prev_out);
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_out   = {out_undef, out_result};
      if (out_valid && out_ready) begin
        n_checks++;
        if (q_exp.size() == 0) begin
          n_fail++;
          $display("FAIL R10 unexpected result %h, expected none", out_result);
        end else begin
          logic [64:0] e;
          string t;
          e = q_exp.pop_front();
          t = q_tag.pop_front();
          if ({out_undef, out_result} != e) begin
            n_fail++;
            $display("FAIL %s: got undef=%0b res=%h, expected undef=%0b res=%h",
                     t, out_undef, out_result, e[64], e[63:0]);
          end
        end
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, got hang expected completion");
    finish_run();
  end

  localparam logic [4:0] OP_NUM = 5'h0C, OP_PLN = 5'h0F;

  initial begin
    logic [31:0] pool [16];
    logic [31:0] lfsr;
    pool = '{P1, N1, PINF, NINF, PZ, NZ, QN1, QN2, SN1, SN2, DEN, PI, N2,
             32'h00800000, 32'h7F7FFFFF, 32'h80000002};
    lfsr = 32'hACE1_1234;
    repeat (3) @(posedge clk);
    #1;
    n_checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      n_fail++;
      $display("FAIL R10 reset: got out_valid=%0b in_ready=%0b, expected 0 1", out_valid, in_ready);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R2/R9 plain max and min on ordinary values.
    send(mk_insn(1, 1, 2'b00, OP_PLN), P1, N2, PI, DEN, "R2 R9 plain max");
    send(mk_insn(1, 1, 2'b10, OP_PLN), P1, N2, PI, DEN, "R2 R9 plain min");
    send(mk_insn(1, 1, 2'b00, OP_NUM), NINF, N1, N2, 32'h80000002, "R9 negatives max");
    send(mk_insn(1, 1, 2'b10, OP_NUM), PINF, P1, DEN, PI, "R9 positives min");
    // R8 signed zeros.
    send(mk_insn(1, 1, 2'b00, OP_PLN), NZ, PZ, NZ, NZ, "R8 max zeros");
    send(mk_insn(1, 1, 2'b10, OP_PLN), PZ, NZ, PZ, PZ, "R8 min zeros");
    // R5 plain NaN rules, first-operand priority and quieting.
    send(mk_insn(1, 1, 2'b00, OP_PLN), P1, QN2, P1, P1, "R5 plain qnan");
    send(mk_insn(1, 1, 2'b10, OP_PLN), SN1, P1, SN2, P1, "R5 R3 plain first snan");
    send(mk_insn(1, 1, 2'b00, OP_PLN), P1, P1, QN1, SN2, "R5 plain pair priority");
    // R6 number variants with quiet NaNs.
    send(mk_insn(1, 1, 2'b00, OP_NUM), QN1, N1, P1, QN2, "R6 num qnan skipped");
    send(mk_insn(1, 1, 2'b10, OP_NUM), QN1, QN2, QN2, QN1, "R6 num all qnan");
    // R7 signalling NaN in number variants.
    send(mk_insn(1, 1, 2'b00, OP_NUM), P1, SN1, P1, P1, "R7 num snan");
    send(mk_insn(1, 1, 2'b10, OP_NUM), SN2, SN1, P1, P1, "R7 num first snan");
    // R3 order: quieted snan at root loses to number.
    send(mk_insn(1, 1, 2'b00, OP_NUM), PI, QN1, SN1, N1, "R3 R7 tree order");
    // R1 illegal encodings.
    send(mk_insn(1, 0, 2'b00, OP_PLN), P1, P1, P1, P1, "R1 U clear");
    send(mk_insn(0, 1, 2'b00, OP_NUM), P1, P1, P1, P1, "R1 Q clear");
    send(mk_insn(1, 1, 2'b01, OP_PLN), P1, P1, P1, P1, "R1 size bit0");
    send(mk_insn(1, 1, 2'b00, 5'h0A), P1, P1, P1, P1, "R1 other opcode");
    // R4 zero extension with all-ones-ish value.
    send(mk_insn(1, 1, 2'b10, OP_PLN), NINF, N1, N1, N1, "R4 R9 upper half clear");

    // R11 back-pressure with pseudo-random special values.
    bp_en = 1'b1;
    for (int i = 0; i < 60; i++) begin
      logic [31:0] w;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      w = mk_insn(1'b1, 1'b1, {lfsr[3], (lfsr[7:4] == 4'hF)}, lfsr[8] ? OP_NUM : OP_PLN);
      send(w, pool[lfsr[12:9]], pool[lfsr[16:13]], pool[lfsr[20:17]], pool[lfsr[24:21]],
           "R11 R3 random stream");
    end
    bp_en = 1'b0;

    repeat (20) @(posedge clk);
    n_checks++;
    if (q_exp.size() != 0) begin
      n_fail++;
      $display("FAIL R10 pending results: got %0d left, expected 0", q_exp.size());
    end
    finish_run();
  end
endmodule